// File: doc/BRIEF.md
# E1 Multiframe Spare-Bit Inserter

This block sits on the transmit path of an E1 framer and overwrites selected bits of the timeslot-0 byte with values supplied by a host. The CRC-4 multiframe has sixteen frames. In frames with even numbers, timeslot 0 carries one international (Si) bit. In frames with odd numbers, it carries an Si bit, a fixed 1, the remote-alarm (A) bit and the five national bits Sa4 to Sa8. The host keeps eight 8-bit data registers, one for each bit group. Each register holds the eight values that the group takes over one multiframe, and the most significant bit is sent first. A ninth register enables each group on its own; a group that is not enabled carries the upstream bit through unchanged.

When the timeslot-0 byte of frame 0 arrives, the block copies all host registers into a working copy and raises a multiframe status flag. For the rest of the multiframe it takes its bits from the working copy. A host write therefore has effect from the next multiframe on. If the host writes nothing, the same values are sent again. The status flag tells the host when to load new data: about 2 ms before the next sampling point. The host clears the flag by writing a 1 to it. Every processed byte appears at the output one clock after its input strobe. The block neither generates the frame alignment word nor computes the CRC.

Top module: `e1_spare_bit_inserter`

## Requirements
- R1: After reset, `ts0Out` is 0, `ts0OutValid` is 0, `mfStatus` is 0, and all host registers and the working copy hold 0.
- R2: Every cycle in which `ts0Strobe` is high gives exactly one cycle with `ts0OutValid` high, on the next clock. A cycle without a strobe gives `ts0OutValid` low on the next clock.
- R3: In a frame with an even number n, output bit 7 is bit (7 - n/2) of the align-Si register (address 0) when control bit 0 is set, and otherwise input bit 7. Bits 6..0 pass through from `ts0In`.
- R4: In a frame with an odd number n, let i = 7 - (n-1)/2. Output bit 6 is always 1. Bit 7 is bit i of the non-align-Si register (address 1) when control bit 1 is set. Bit 5 is bit i of the A register (address 2) when control bit 2 is set. Output bit (4-k) is bit i of the Sa(4+k) register (address 3+k, k = 0..4) when control bit (3+k) is set. Every bit that is not enabled passes through from `ts0In`.
- R5: The strobe with `frameNum` = 0 copies all host registers, the control register included, into the working copy. Frame 0 already uses the copied values. A host write in the same cycle as that strobe, or later in the multiframe, changes only the host register and takes effect from the next multiframe. Registers that are not rewritten are sent again unchanged.
- R6: `mfStatus` goes to 1 on the clock of the frame-0 strobe and stays at 1. A write of data bit 0 = 1 to address 9 clears it; a write of 0 to address 9 leaves it unchanged. When a set and a clear fall in the same cycle, the set wins.
- R7: Host addresses 0 to 7 select align Si, non-align Si, A and Sa4 to Sa8 in that order. Address 8 is the group-enable register: bit 0 align Si, bit 1 non-align Si, bit 2 A, bits 3 to 7 Sa4 to Sa8. A group whose enable is 0 passes its input bits through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 4 | Host register address (0-8 registers, 9 status clear) |
| hostWrData | input | 8 | Host write data |
| ts0Strobe | input | 1 | Timeslot-0 byte present on `ts0In` |
| frameNum | input | 4 | Frame number within the multiframe, 0 to 15 |
| ts0In | input | 8 | Upstream timeslot-0 byte |
| ts0Out | output | 8 | Timeslot-0 byte after insertion, registered |
| ts0OutValid | output | 1 | `ts0Out` is valid this cycle |
| mfStatus | output | 1 | Multiframe sampling flag, cleared by the host with a write of 1 |

## Verification
The working copy cannot be read by the host, so a fault in it shows up only as wrong inserted bits. Such a fault may stay hidden for up to sixteen frames, until the frame that uses the bad bit position, or until a multiframe in which the host data changes. For this reason the bench runs full multiframes with distinct bit patterns in every register. It also writes in mid-multiframe, sends multiframes with no update, and uses partial enable masks, so that a stale, early or misrouted bit shows as a miscompare within one multiframe. A fault in the status flag shows at once on `mfStatus`, at the clock after the frame-0 strobe or after the clearing write.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_W     = 4;
  localparam int FRAME_CNT   = 1 << FRAME_W;
  localparam int IDX_W       = FRAME_W - 1;
  localparam int ADDR_W      = 4;
  localparam int SA_CNT      = 5;
  localparam int DATA_REGS   = 3 + SA_CNT;
  localparam int REG_CNT     = DATA_REGS + 1;
  localparam int IDX_ALIGN   = 0;
  localparam int IDX_NALIGN  = 1;
  localparam int IDX_ABIT    = 2;
  localparam int IDX_SA0     = 3;
  localparam int IDX_CTRL    = DATA_REGS;
  localparam int CLR_ADDR    = REG_CNT;
  localparam int POS_SI      = 7;
  localparam int POS_FIX     = 6;
  localparam int POS_ABIT    = 5;
  localparam int POS_SA0     = 4;

  typedef struct packed {
    logic               sample;
    logic               fire;
    logic               oddFrame;
    logic [IDX_W-1:0]   bitIdx;
    logic [REG_CNT-1:0] wrSel;
  } ctlStrobe_t;
endpackage

// File: rtl/e1sa_ctrl.sv
module e1sa_ctrl
  import e1sa_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic               clrBit,
  input  logic               ts0Strobe,
  input  logic [FRAME_W-1:0] frameNum,
  output ctlStrobe_t         strb,
  output logic               mfStatus
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'((FRAME_CNT / 2) - 1);

  logic clrReq;
  logic sampleNow;
  logic mfFlag;

  assign sampleNow = ts0Strobe && (frameNum == '0);
  assign clrReq    = hostWrEn && (hostAddr == ADDR_W'(CLR_ADDR)) && clrBit;

  always_comb begin
    strb          = '0;
    strb.sample   = sampleNow;
    strb.fire     = ts0Strobe;
    strb.oddFrame = frameNum[0];
    strb.bitIdx   = LAST_IDX - frameNum[FRAME_W-1:1];
    for (int r = 0; r < REG_CNT; r++) begin
      strb.wrSel[r] = hostWrEn && (hostAddr == ADDR_W'(r));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          mfFlag <= 1'b0;
    else if (sampleNow) mfFlag <= 1'b1;
    else if (clrReq)    mfFlag <= 1'b0;
  end

  assign mfStatus = mfFlag;

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    ts0Strobe && (frameNum == '0) |=> mfStatus);

  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == ADDR_W'(CLR_ADDR) && clrBit && !ts0Strobe) |=> !mfStatus);

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ts0Strobe && !hostWrEn) |=> $stable(mfStatus));
endmodule

// File: rtl/e1sa_datapath.sv
module e1sa_datapath
  import e1sa_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] ts0In,
  output logic [BYTE_W-1:0] ts0Out,
  output logic              ts0OutValid
);
  logic [DATA_REGS:0][BYTE_W-1:0] hostReg;
  logic [DATA_REGS:0][BYTE_W-1:0] workCopy;
  logic [DATA_REGS:0][BYTE_W-1:0] srcReg;
  logic [DATA_REGS-1:0]           selBit;
  logic [BYTE_W-1:0]              ctlMask;
  logic [BYTE_W-1:0]              nextByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostReg <= '0;
    end else begin
      for (int r = 0; r <= DATA_REGS; r++) begin
        if (strb.wrSel[r]) hostReg[r] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            workCopy <= '0;
    else if (strb.sample) workCopy <= hostReg;
  end

  assign srcReg  = strb.sample ? hostReg : workCopy;
  assign ctlMask = srcReg[IDX_CTRL];

  genvar g;
  generate
    for (g = 0; g < DATA_REGS; g++) begin : g_pick
      assign selBit[g] = srcReg[g][strb.bitIdx];
    end
  endgenerate

  always_comb begin
    nextByte = ts0In;
    if (strb.oddFrame) begin
      nextByte[POS_FIX] = 1'b1;
      if (ctlMask[IDX_NALIGN]) nextByte[POS_SI]   = selBit[IDX_NALIGN];
      if (ctlMask[IDX_ABIT])   nextByte[POS_ABIT] = selBit[IDX_ABIT];
      for (int k = 0; k < SA_CNT; k++) begin
        if (ctlMask[IDX_SA0 + k]) nextByte[POS_SA0 - k] = selBit[IDX_SA0 + k];
      end
    end else begin
      if (ctlMask[IDX_ALIGN]) nextByte[POS_SI] = selBit[IDX_ALIGN];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ts0Out      <= '0;
      ts0OutValid <= 1'b0;
    end else begin
      ts0OutValid <= strb.fire;
      if (strb.fire) ts0Out <= nextByte;
    end
  end

  p_out_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> ts0OutValid);

  p_out_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fire |=> !ts0OutValid);

  p_fixed_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && strb.oddFrame) |=> ts0Out[POS_FIX]);

  p_even_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && !strb.oddFrame) |=> ts0Out[POS_FIX:0] == $past(ts0In[POS_FIX:0]));

  p_copy_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sample |=> $stable(workCopy));
endmodule

// File: rtl/e1_spare_bit_inserter.sv
module e1_spare_bit_inserter
  import e1sa_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic [BYTE_W-1:0]  hostWrData,
  input  logic               ts0Strobe,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic [BYTE_W-1:0]  ts0In,
  output logic [BYTE_W-1:0]  ts0Out,
  output logic               ts0OutValid,
  output logic               mfStatus
);
  ctlStrobe_t strb;

  e1sa_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostWrEn  (hostWrEn),
    .hostAddr  (hostAddr),
    .clrBit    (hostWrData[0]),
    .ts0Strobe (ts0Strobe),
    .frameNum  (frameNum),
    .strb      (strb),
    .mfStatus  (mfStatus)
  );

  e1sa_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (hostWrData),
    .ts0In       (ts0In),
    .ts0Out      (ts0Out),
    .ts0OutValid (ts0OutValid)
  );
endmodule

// File: tb/e1_spare_bit_inserter_bench.sv
`timescale 1ns/1ps
module e1_spare_bit_inserter_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWrEn = 1'b0;
  logic [3:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic       ts0Strobe = 1'b0;
  logic [3:0] frameNum = '0;
  logic [7:0] ts0In = '0;
  logic [7:0] ts0Out;
  logic       ts0OutValid;
  logic       mfStatus;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [7:0] hostM [9];
  logic [7:0] workM [9];
  logic       statusM = 1'b0;
  logic [7:0] expQ [$];
  string      tagQ [$];

  always #2.5 clk = ~clk;

  e1_spare_bit_inserter u_e1_spare_bit_inserter (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .ts0Strobe(ts0Strobe), .frameNum(frameNum),
    .ts0In(ts0In), .ts0Out(ts0Out), .ts0OutValid(ts0OutValid), .mfStatus(mfStatus)
  );

  function automatic logic [7:0] calcExp(input logic [3:0] fr, input logic [7:0] inB);
    logic [7:0] o;
    logic [7:0] ctl;
    int idx;
    o   = inB;
    ctl = workM[8];
    idx = 7 - int'(fr[3:1]);
    if (fr[0]) begin
      o[6] = 1'b1;
      if (ctl[1]) o[7] = workM[1][idx];
      if (ctl[2]) o[5] = workM[2][idx];
      for (int k = 0; k < 5; k++) if (ctl[3+k]) o[4-k] = workM[3+k][idx];
    end else if (ctl[0]) begin
      o[7] = workM[0][idx];
    end
    return o;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected bytes as the design produces them
  always @(negedge clk) begin
    if (rstN && ts0OutValid) begin
      if (expQ.size() == 0) begin
        check({7'd0, ts0OutValid}, 8'h00, "R2 unexpected valid");
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(ts0Out, e, t);
      end
    end
  end

  // all driver tasks start and end at a falling edge
  task automatic applyFrame(input logic [3:0] fr, input logic [7:0] inB, input string tag);
    ts0Strobe = 1'b1; frameNum = fr; ts0In = inB;
    if (fr == 0) begin
      for (int r = 0; r < 9; r++) workM[r] = hostM[r];
      statusM = 1'b1;
    end
    expQ.push_back(calcExp(fr, inB));
    tagQ.push_back(tag);
    @(negedge clk);
    ts0Strobe = 1'b0;
  endtask

  task automatic hostWrite(input logic [3:0] a, input logic [7:0] d);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
    if (a < 9) hostM[a] = d;
    else if (a == 9 && d[0]) statusM = 1'b0;
  endtask

  task automatic frameAndWrite(input logic [3:0] fr, input logic [7:0] inB,
                               input logic [3:0] a, input logic [7:0] d, input string tag);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    ts0Strobe = 1'b1; frameNum = fr; ts0In = inB;
    if (fr == 0) for (int r = 0; r < 9; r++) workM[r] = hostM[r];
    expQ.push_back(calcExp(fr, inB));
    tagQ.push_back(tag);
    if (a < 9) hostM[a] = d;
    if (fr == 0) statusM = 1'b1;
    else if (a == 9 && d[0]) statusM = 1'b0;
    @(negedge clk);
    hostWrEn = 1'b0; ts0Strobe = 1'b0;
  endtask

  task automatic runMultiframe(input logic [7:0] seed, input string tag);
    for (int f = 0; f < 16; f++) applyFrame(4'(f), 8'(f * 17) ^ seed, tag);
  endtask

  task automatic checkStatus(input string tag);
    check({7'd0, mfStatus}, {7'd0, statusM}, tag);
  endtask

  initial begin
    for (int w = 0; w < 100000 && !finished; w++) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 9; r++) begin hostM[r] = '0; workM[r] = '0; end
    repeat (3) @(negedge clk);
    check(ts0Out, 8'h00, "R1 output after reset");
    check({7'd0, ts0OutValid}, 8'h00, "R1 valid after reset");
    check({7'd0, mfStatus}, 8'h00, "R1 status after reset");
    rstN = 1'b1;
    @(negedge clk);
    // all-zero registers with reset control: pure pass-through apart from bit 6
    applyFrame(4'd0, 8'hFF, "R1 zero regs even");
    applyFrame(4'd1, 8'h00, "R1 zero regs odd");
    @(negedge clk);
    check({7'd0, ts0OutValid}, 8'h00, "R2 idle gives no valid");
    hostWrite(4'd9, 8'h01); statusM = 1'b0;

    // R7 address map, distinct patterns per register
    hostWrite(4'd0, 8'hA5); hostWrite(4'd1, 8'h3C); hostWrite(4'd2, 8'hF0);
    hostWrite(4'd3, 8'h96); hostWrite(4'd4, 8'h0F); hostWrite(4'd5, 8'hC3);
    hostWrite(4'd6, 8'h5A); hostWrite(4'd7, 8'h81); hostWrite(4'd8, 8'hFF);
    checkStatus("R6 status low before sampling");
    runMultiframe(8'h2B, "R3/R4 full insertion");
    checkStatus("R6 status set at frame 0");
    hostWrite(4'd9, 8'h00);
    checkStatus("R6 writing 0 keeps status");
    hostWrite(4'd9, 8'h01);
    checkStatus("R6 writing 1 clears status");

    // R5: mid-multiframe writes affect only the next multiframe
    for (int f = 0; f < 16; f++) begin
      if (f == 3) frameAndWrite(4'd3, 8'h44, 4'd0, 8'h0F, "R5 write during frame");
      else if (f == 8) frameAndWrite(4'd8, 8'h99, 4'd2, 8'h00, "R5 write during frame");
      else applyFrame(4'(f), 8'(f * 29) ^ 8'h6E, "R5 old copy kept");
    end
    hostWrite(4'd7, 8'h7E);
    runMultiframe(8'hC1, "R5 new copy used");
    runMultiframe(8'hC1, "R5 repeat without update");

    // R7 group enables
    hostWrite(4'd8, 8'h00);
    runMultiframe(8'h00, "R7 all groups off");
    runMultiframe(8'h5D, "R7 all groups off");
    hostWrite(4'd8, 8'h05);
    runMultiframe(8'hE7, "R7 align Si and A only");
    hostWrite(4'd8, 8'hA8);
    runMultiframe(8'h33, "R7 Sa4 Sa6 Sa8 only");

    // R5 same-cycle write not captured; R6 set beats clear
    hostWrite(4'd8, 8'h02);
    frameAndWrite(4'd0, 8'h12, 4'd8, 8'hFF, "R5 same-cycle write at frame 0");
    checkStatus("R6 set after frame 0");
    for (int f = 1; f < 16; f++) applyFrame(4'(f), 8'(f * 7), "R5 control from old copy");
    frameAndWrite(4'd0, 8'h21, 4'd9, 8'h01, "R6 frame 0 with clear");
    checkStatus("R6 set wins over clear");
    for (int f = 1; f < 16; f++) applyFrame(4'(f), 8'(f * 11) ^ 8'hA0, "R3/R4 after control change");

    repeat (4) @(negedge clk);
    check(8'(expQ.size()), 8'h00, "R2 every strobe produced output");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule